// File: doc/BRIEF.md
# Checkpoint Creation and Release Controller

This block manages rename-state checkpoints for a core that retires instructions out of order and has no reorder buffer. It watches each decoded instruction (valid, branch, store) and pipeline flush events. From these it decides whether the instruction must open a new checkpoint. Checkpoints live in a small circular table. Each slot holds a copy of the mapping valid bits, a copy of the future-free bits, and a count of the instructions still active in that checkpoint.

The count of a slot goes up when an instruction is allocated to it and down when such an instruction completes. The oldest slot is released once it has drained and a younger slot exists. On release, the block hands its stored future-free bits to the free list. A misprediction restore to slot k gives back the saved state of k, drops every younger slot and clears the distance counters. The block does not hold rename state itself. It only produces capture, restore and release strobes with their data.

Top module: `ckpt_ctrl`

## Requirements
- R1: After reset no strobe is active, `dec_stall` is low, and the first accepted instruction opens checkpoint 0, because an empty table always requires a new checkpoint.
- R2: A branch opens a new checkpoint when at least 64 instructions (the opening one included) have been accepted into the current checkpoint. A branch seen after only 63 does not open one.
- R3: When 512 instructions have been accepted into the current checkpoint, the next instruction opens a new checkpoint whatever its kind.
- R4: When 64 stores have been accepted into the current checkpoint, the next instruction opens a new checkpoint.
- R5: A pulse on `flush_in` makes the next accepted instruction open a new checkpoint. The request stays armed across stalled cycles.
- R6: An instruction that opens a checkpoint is given the next free slot on `dec_ckpt_id` in the same cycle. One cycle later `snap_strobe` pulses with that slot on `snap_ckpt_id`, and the slot stores `map_valid_in` and `future_free_in` as they were on the accepting edge. An instruction that opens nothing gets the youngest slot.
- R7: When several opening rules hold on the same instruction, exactly one checkpoint is opened.
- R8: With 8 live slots, an instruction that needs a new checkpoint is held by `dec_stall` and changes nothing. An instruction that needs none is still accepted.
- R9: Only the oldest slot is released, and only when its active count is zero and it is not the youngest. One cycle later `release_strobe` pulses with its id and its stored future-free bits on `release_free_mask`. Slots are released in the order they were opened.
- R10: A restore to a live slot k raises `restore_strobe` one cycle later with k's stored map and future-free bits. Slots younger than k are discarded, so the next new checkpoint is k+1 modulo 8. The instruction and store counters are cleared. `dec_stall` is high during the restore cycle. A restore to a slot that is not live has no effect.
- R11: A slot is not released while any instruction allocated to it has not completed. An allocation and a completion on the same slot in one cycle cancel.
- R12: A release of the oldest slot and the opening of a new checkpoint may happen in the same cycle, and both strobes then pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_is_branch | input | 1 | Instruction is a branch |
| dec_is_store | input | 1 | Instruction is a store |
| dec_stall | output | 1 | Instruction not accepted this cycle |
| dec_ckpt_id | output | 3 | Slot the instruction is allocated to |
| flush_in | input | 1 | Pipeline flush event |
| map_valid_in | input | 32 | Current mapping valid bits |
| future_free_in | input | 32 | Current future-free bits |
| cmpl_valid | input | 1 | An instruction completes |
| cmpl_ckpt_id | input | 3 | Slot of the completing instruction |
| restore_valid | input | 1 | Misprediction restore request |
| restore_ckpt_id | input | 3 | Slot to restore to |
| snap_strobe | output | 1 | Capture the rename state now |
| snap_ckpt_id | output | 3 | Slot being captured |
| restore_strobe | output | 1 | Restore the rename state now |
| restore_map_valid | output | 32 | Saved mapping valid bits |
| restore_future_free | output | 32 | Saved future-free bits |
| release_strobe | output | 1 | Oldest slot released |
| release_ckpt_id | output | 3 | Released slot |
| release_free_mask | output | 32 | Registers returned to the free list |

## Verification
Two events can fall in the same cycle: the release of a drained oldest slot and the opening of a new checkpoint. The bench provokes this by arming a flush, completing the last instruction of the oldest slot, and then presenting a plain instruction on the following cycle. It judges the result by seeing `snap_strobe` and `release_strobe` on the same sampled cycle, with ids and masks that match the scoreboard queues. Several opening rules landing on one instruction is also provoked (flush, branch distance and store count together), and the bench confirms that only one capture appears.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    localparam int CKPT_DEPTH_DEF  = 8;
    localparam int PREG_BITS_DEF   = 32;
    localparam int BRANCH_GAP_DEF  = 64;
    localparam int INST_CAP_DEF    = 512;
    localparam int STORE_CAP_DEF   = 64;

    // Reasons an instruction may have to open a checkpoint
    typedef struct packed {
        logic empty_tbl;
        logic after_flush;
        logic branch_gap;
        logic inst_cap;
        logic store_cap;
    } trig_cause_t;

endpackage

// File: rtl/ckpt_trigger.sv
module ckpt_trigger
    import ckpt_pkg::*;
#(
    parameter int BRANCH_GAP = BRANCH_GAP_DEF,
    parameter int INST_CAP   = INST_CAP_DEF,
    parameter int STORE_CAP  = STORE_CAP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_is_branch,
    input  logic dec_is_store,
    input  logic flush_in,
    input  logic tbl_empty,
    input  logic accept,
    input  logic restore,
    output logic need
);

    localparam int IC_W = $clog2(INST_CAP + 1);
    localparam int SC_W = $clog2(STORE_CAP + 1);

    typedef struct packed {
        logic [IC_W-1:0] inst;
        logic [SC_W-1:0] st;
        logic            pend;
    } trig_state_t;

    trig_state_t s_q, s_d;
    trig_cause_t cause;

    always_comb begin
        cause.empty_tbl   = tbl_empty;
        cause.after_flush = s_q.pend;
        cause.branch_gap  = dec_is_branch && (s_q.inst >= IC_W'(BRANCH_GAP));
        cause.inst_cap    = (s_q.inst >= IC_W'(INST_CAP));
        cause.store_cap   = (s_q.st >= SC_W'(STORE_CAP));
        need = dec_valid && (cause != '0);

        s_d      = s_q;
        s_d.pend = flush_in || (s_q.pend && !(accept && need));
        if (restore) begin
            s_d.inst = '0;
            s_d.st   = '0;
        end else if (accept) begin
            if (need) begin
                s_d.inst = IC_W'(1);
                s_d.st   = SC_W'(dec_is_store);
            end else begin
                s_d.inst = s_q.inst + IC_W'(1);
                s_d.st   = s_q.st + SC_W'(dec_is_store);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_INST_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.inst <= IC_W'(INST_CAP)); // R3
    AST_STORE_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st <= SC_W'(STORE_CAP)); // R4
    AST_RESTORE_CLEARS_DIST: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (s_q.inst == '0 && s_q.st == '0)); // R10

endmodule

// File: rtl/ckpt_table.sv
module ckpt_table #(
    parameter int  DEPTH = 8,
    parameter int  PREGS = 32,
    parameter int  ACT_W = 12,
    localparam int ID_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             alloc,
    input  logic [PREGS-1:0] map_in,
    input  logic [PREGS-1:0] ff_in,
    input  logic             cmpl_valid,
    input  logic [ID_W-1:0]  cmpl_id,
    input  logic             restore_valid,
    input  logic [ID_W-1:0]  restore_id,
    output logic [ID_W-1:0]  cur_id,
    output logic             full,
    output logic             empty,
    output logic             snap_v,
    output logic [ID_W-1:0]  snap_id,
    output logic             rest_v,
    output logic [PREGS-1:0] rest_map,
    output logic [PREGS-1:0] rest_ff,
    output logic             rel_v,
    output logic [ID_W-1:0]  rel_id,
    output logic [PREGS-1:0] rel_mask
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PREGS-1:0] map;
        logic [DEPTH-1:0][PREGS-1:0] ff;
        logic [DEPTH-1:0][ACT_W-1:0] act;
        logic [ID_W-1:0]             head;
        logic [ID_W-1:0]             tail;
        logic [CNT_W-1:0]            cnt;
        logic                        snap_v;
        logic [ID_W-1:0]             snap_id;
        logic                        rest_v;
        logic [PREGS-1:0]            rest_map;
        logic [PREGS-1:0]            rest_ff;
        logic                        rel_v;
        logic [ID_W-1:0]             rel_id;
        logic [PREGS-1:0]            rel_mask;
    } tbl_state_t;

    tbl_state_t s_q, s_d;

    function automatic logic [ID_W-1:0] ring_next(input logic [ID_W-1:0] p);
        return (p == ID_W'(DEPTH - 1)) ? '0 : p + ID_W'(1);
    endfunction

    function automatic logic [ID_W-1:0] ring_prev(input logic [ID_W-1:0] p);
        return (p == '0) ? ID_W'(DEPTH - 1) : p - ID_W'(1);
    endfunction

    // Distance of a slot from the oldest one
    function automatic logic [CNT_W-1:0] ring_off(input logic [ID_W-1:0] id,
                                                  input logic [ID_W-1:0] base);
        return (id >= base) ? (CNT_W'(id) - CNT_W'(base))
                            : (CNT_W'(DEPTH) + CNT_W'(id) - CNT_W'(base));
    endfunction

    logic [DEPTH-1:0] live;

    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign live[g] = ring_off(ID_W'(g), s_q.head) < s_q.cnt;
    end

    logic rel_ok, rest_ok;

    always_comb begin
        logic add_e, sub_e;
        cur_id  = take ? s_q.tail : ring_prev(s_q.tail);
        full    = (s_q.cnt == CNT_W'(DEPTH));
        empty   = (s_q.cnt == '0);
        rel_ok  = (s_q.cnt >= CNT_W'(2)) && (s_q.act[s_q.head] == '0) && !restore_valid;
        rest_ok = restore_valid && live[restore_id];

        s_d        = s_q;
        s_d.snap_v = 1'b0;
        s_d.rest_v = 1'b0;
        s_d.rel_v  = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            add_e = alloc && (cur_id == ID_W'(i));
            sub_e = cmpl_valid && (cmpl_id == ID_W'(i)) && live[i] && (s_q.act[i] != '0);
            if (take && (s_q.tail == ID_W'(i))) begin
                s_d.act[i] = ACT_W'(add_e);
                s_d.map[i] = map_in;
                s_d.ff[i]  = ff_in;
            end else begin
                s_d.act[i] = s_q.act[i] + ACT_W'(add_e) - ACT_W'(sub_e);
            end
        end

        if (take) begin
            s_d.tail    = ring_next(s_q.tail);
            s_d.snap_v  = 1'b1;
            s_d.snap_id = s_q.tail;
        end

        if (rest_ok) begin
            s_d.tail     = ring_next(restore_id);
            s_d.cnt      = ring_off(restore_id, s_q.head) + CNT_W'(1);
            s_d.rest_v   = 1'b1;
            s_d.rest_map = s_q.map[restore_id];
            s_d.rest_ff  = s_q.ff[restore_id];
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(take) - CNT_W'(rel_ok);
        end

        if (rel_ok) begin
            s_d.head     = ring_next(s_q.head);
            s_d.rel_v    = 1'b1;
            s_d.rel_id   = s_q.head;
            s_d.rel_mask = s_q.ff[s_q.head];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign snap_v   = s_q.snap_v;
    assign snap_id  = s_q.snap_id;
    assign rest_v   = s_q.rest_v;
    assign rest_map = s_q.rest_map;
    assign rest_ff  = s_q.rest_ff;
    assign rel_v    = s_q.rel_v;
    assign rel_id   = s_q.rel_id;
    assign rel_mask = s_q.rel_mask;

    AST_TABLE_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R8
    AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !full); // R8
    AST_RELEASE_LEAVES_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rel_v |-> ($past(s_q.cnt) >= CNT_W'(2))); // R9
    AST_RELEASE_NOT_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rel_v |-> !s_q.rest_v); // R10

endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
    import ckpt_pkg::*;
#(
    parameter int  NUM_CKPT   = CKPT_DEPTH_DEF,
    parameter int  NUM_PREGS  = PREG_BITS_DEF,
    parameter int  BRANCH_GAP = BRANCH_GAP_DEF,
    parameter int  INST_CAP   = INST_CAP_DEF,
    parameter int  STORE_CAP  = STORE_CAP_DEF,
    localparam int ID_W       = $clog2(NUM_CKPT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic                 dec_is_branch,
    input  logic                 dec_is_store,
    output logic                 dec_stall,
    output logic [ID_W-1:0]      dec_ckpt_id,
    input  logic                 flush_in,
    input  logic [NUM_PREGS-1:0] map_valid_in,
    input  logic [NUM_PREGS-1:0] future_free_in,
    input  logic                 cmpl_valid,
    input  logic [ID_W-1:0]      cmpl_ckpt_id,
    input  logic                 restore_valid,
    input  logic [ID_W-1:0]      restore_ckpt_id,
    output logic                 snap_strobe,
    output logic [ID_W-1:0]      snap_ckpt_id,
    output logic                 restore_strobe,
    output logic [NUM_PREGS-1:0] restore_map_valid,
    output logic [NUM_PREGS-1:0] restore_future_free,
    output logic                 release_strobe,
    output logic [ID_W-1:0]      release_ckpt_id,
    output logic [NUM_PREGS-1:0] release_free_mask
);

    // Active counts may grow past the distance cap after a restore
    localparam int ACT_W = $clog2(INST_CAP + 1) + 2;

    logic need, accept, take, tbl_full, tbl_empty;

    always_comb begin
        dec_stall = restore_valid || (need && tbl_full);
        accept    = dec_valid && !dec_stall;
        take      = accept && need;
    end

    ckpt_trigger #(
        .BRANCH_GAP (BRANCH_GAP),
        .INST_CAP   (INST_CAP),
        .STORE_CAP  (STORE_CAP)
    ) u_trigger (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_valid     (dec_valid),
        .dec_is_branch (dec_is_branch),
        .dec_is_store  (dec_is_store),
        .flush_in      (flush_in),
        .tbl_empty     (tbl_empty),
        .accept        (accept),
        .restore       (restore_valid),
        .need          (need)
    );

    ckpt_table #(
        .DEPTH (NUM_CKPT),
        .PREGS (NUM_PREGS),
        .ACT_W (ACT_W)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .alloc         (accept),
        .map_in        (map_valid_in),
        .ff_in         (future_free_in),
        .cmpl_valid    (cmpl_valid),
        .cmpl_id       (cmpl_ckpt_id),
        .restore_valid (restore_valid),
        .restore_id    (restore_ckpt_id),
        .cur_id        (dec_ckpt_id),
        .full          (tbl_full),
        .empty         (tbl_empty),
        .snap_v        (snap_strobe),
        .snap_id       (snap_ckpt_id),
        .rest_v        (restore_strobe),
        .rest_map      (restore_map_valid),
        .rest_ff       (restore_future_free),
        .rel_v         (release_strobe),
        .rel_id        (release_ckpt_id),
        .rel_mask      (release_free_mask)
    );

    AST_STALL_BLOCKS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_stall) |=> !snap_strobe); // R8
    AST_RESTORE_HOLDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> dec_stall); // R10

endmodule

// File: tb/tb_ckpt_ctrl.sv
`timescale 1ns/1ps
module tb_ckpt_ctrl;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_is_branch = 0, dec_is_store = 0, flush_in = 0;
    logic [31:0] map_valid_in = '0, future_free_in = '0;
    logic cmpl_valid = 0, restore_valid = 0;
    logic [2:0] cmpl_ckpt_id = '0, restore_ckpt_id = '0;
    logic dec_stall, snap_strobe, restore_strobe, release_strobe;
    logic [2:0] dec_ckpt_id, snap_ckpt_id, release_ckpt_id;
    logic [31:0] restore_map_valid, restore_future_free, release_free_mask;

    always #4 clk = ~clk;

    ckpt_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_is_branch(dec_is_branch), .dec_is_store(dec_is_store),
        .dec_stall(dec_stall), .dec_ckpt_id(dec_ckpt_id), .flush_in(flush_in),
        .map_valid_in(map_valid_in), .future_free_in(future_free_in),
        .cmpl_valid(cmpl_valid), .cmpl_ckpt_id(cmpl_ckpt_id),
        .restore_valid(restore_valid), .restore_ckpt_id(restore_ckpt_id),
        .snap_strobe(snap_strobe), .snap_ckpt_id(snap_ckpt_id),
        .restore_strobe(restore_strobe), .restore_map_valid(restore_map_valid),
        .restore_future_free(restore_future_free),
        .release_strobe(release_strobe), .release_ckpt_id(release_ckpt_id),
        .release_free_mask(release_free_mask)
    );

    int checks = 0, failures = 0, pcount = 0, snaps_seen = 0;
    bit both_seen = 0, done = 0;

    typedef struct { int due; int id; logic [31:0] a; logic [31:0] b; } exp_t;
    exp_t q_snap[$], q_rel[$], q_rst[$];

    // Requirement-level reference state
    int m_head = 0, m_tail = 0, m_cnt = 0, m_inst = 0, m_st = 0;
    bit m_fp = 0;
    int m_act[N];
    logic [31:0] m_map[N], m_ff[N];

    always @(posedge clk) pcount++;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actv, expv);
        end
    endtask

    function automatic bit m_live(input int id);
        return ((id - m_head + N) % N) < m_cnt;
    endfunction

    // Monitor: pops expected items from the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            bit due;
            due = (q_snap.size() > 0) && (q_snap[0].due == pcount);
            if (snap_strobe || due) begin
                chk(snap_strobe == due, "R6", "capture strobe", snap_strobe, due);
                if (snap_strobe && due) begin
                    chk(snap_ckpt_id == q_snap[0].id, "R6", "capture slot", snap_ckpt_id, q_snap[0].id);
                    void'(q_snap.pop_front());
                end
            end
            due = (q_rel.size() > 0) && (q_rel[0].due == pcount);
            if (release_strobe || due) begin
                chk(release_strobe == due, "R9", "release strobe", release_strobe, due);
                if (release_strobe && due) begin
                    chk(release_ckpt_id == q_rel[0].id, "R9", "release slot", release_ckpt_id, q_rel[0].id);
                    chk(release_free_mask == q_rel[0].b, "R9", "free mask", release_free_mask, q_rel[0].b);
                    void'(q_rel.pop_front());
                end
            end
            due = (q_rst.size() > 0) && (q_rst[0].due == pcount);
            if (restore_strobe || due) begin
                chk(restore_strobe == due, "R10", "restore strobe", restore_strobe, due);
                if (restore_strobe && due) begin
                    chk(restore_map_valid == q_rst[0].a, "R10", "restored map", restore_map_valid, q_rst[0].a);
                    chk(restore_future_free == q_rst[0].b, "R10", "restored free bits", restore_future_free, q_rst[0].b);
                    void'(q_rst.pop_front());
                end
            end
            if (snap_strobe) snaps_seen++;
            if (snap_strobe && release_strobe) both_seen = 1;
        end
    end

    // Driver: applies one cycle of stimulus and pushes expected results
    task automatic step(input bit v, input bit br, input bit st, input bit fl,
                        input bit cv, input int cid, input bit rv, input int rid,
                        input string tag);
        bit need, stall, acc, take, rel, rok;
        int cur;
        logic [31:0] pc32;
        exp_t e;
        @(negedge clk);
        pc32 = 32'(pcount);
        dec_valid = v; dec_is_branch = br; dec_is_store = st; flush_in = fl;
        cmpl_valid = cv; cmpl_ckpt_id = 3'(cid);
        restore_valid = rv; restore_ckpt_id = 3'(rid);
        map_valid_in = {pc32[15:0], ~pc32[15:0]};
        future_free_in = (pc32 * 32'h0001_0003) ^ 32'hC3C3_0F0F;
        #1;
        need  = v && (m_cnt == 0 || m_fp || (br && m_inst >= 64) || m_inst >= 512 || m_st >= 64);
        stall = rv || (need && m_cnt == N);
        chk(dec_stall == stall, tag, "stall", dec_stall, stall);
        acc  = v && !stall;
        take = acc && need;
        cur  = take ? m_tail : (m_tail + N - 1) % N;
        if (acc) chk(dec_ckpt_id == 3'(cur), tag, "allocated slot", dec_ckpt_id, cur);
        rel = (m_cnt >= 2) && (m_act[m_head] == 0) && !rv;
        rok = rv && m_live(rid);
        if (cv && m_live(cid) && m_act[cid] > 0) m_act[cid]--;
        e.due = pcount + 1;
        if (take) begin
            m_act[m_tail] = 1;
            m_map[m_tail] = map_valid_in;
            m_ff[m_tail]  = future_free_in;
            e.id = m_tail; e.a = '0; e.b = '0;
            q_snap.push_back(e);
            m_tail = (m_tail + 1) % N;
            m_cnt++;
        end else if (acc) begin
            m_act[cur]++;
        end
        if (rel) begin
            e.id = m_head; e.a = '0; e.b = m_ff[m_head];
            q_rel.push_back(e);
            m_head = (m_head + 1) % N;
            m_cnt--;
        end
        if (rok) begin
            e.id = rid; e.a = m_map[rid]; e.b = m_ff[rid];
            q_rst.push_back(e);
            m_cnt  = ((rid - m_head + N) % N) + 1;
            m_tail = (rid + 1) % N;
        end
        if (rv) begin
            m_inst = 0; m_st = 0;
        end else if (acc) begin
            if (take) begin m_inst = 1; m_st = int'(st); end
            else begin m_inst++; m_st += int'(st); end
        end
        m_fp = fl || (m_fp && !take);
    endtask

    task automatic plain(input string tag);  step(1,0,0,0,0,0,0,0,tag); endtask
    task automatic store(input string tag);  step(1,0,1,0,0,0,0,0,tag); endtask
    task automatic branch(input string tag); step(1,1,0,0,0,0,0,0,tag); endtask
    task automatic flush(input string tag);  step(0,0,0,1,0,0,0,0,tag); endtask
    task automatic idle(input string tag);   step(0,0,0,0,0,0,0,0,tag); endtask

    task automatic drain_head(input string tag);
        while (m_act[m_head] > 0) step(0,0,0,0,1,m_head,0,0,tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0;
        for (int i = 0; i < N; i++) begin m_act[i] = 0; m_map[i] = '0; m_ff[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: quiet outputs after reset
        chk(!snap_strobe && !release_strobe && !restore_strobe, "R1", "strobes after reset",
            {snap_strobe, release_strobe, restore_strobe}, 0);
        chk(dec_stall == 1'b0, "R1", "stall after reset", dec_stall, 0);

        plain("R1");                                 // opens slot 0
        repeat (62) plain("R2");                     // 63 in slot 0
        branch("R2");                                // too close, no capture
        branch("R2");                                // opens slot 1

        // R11: allocation and completion interleaved, same-slot cancel
        step(1,0,0,0,1,0,0,0,"R11");
        step(1,0,0,0,1,1,0,0,"R11");
        drain_head("R11");
        idle("R9");                                  // slot 0 released

        store("R4");
        repeat (63) store("R4");
        plain("R4");                                 // store rule opens

        repeat (511) plain("R3");
        plain("R3");                                 // cap rule opens

        flush("R5");
        plain("R5");                                 // flush rule opens
        plain("R5");

        // R7: flush, branch distance and store count on one instruction
        repeat (64) store("R7");
        flush("R7");
        idle("R7");
        s0 = snaps_seen;
        branch("R7");
        plain("R7");
        idle("R7");
        idle("R7");
        chk(snaps_seen - s0 == 1, "R7", "captures from combined rules", snaps_seen - s0, 1);

        // R12: release and capture in the same cycle
        flush("R12");
        drain_head("R12");
        plain("R12");
        idle("R12");
        idle("R12");
        chk(both_seen, "R12", "release with capture", both_seen, 1);

        // R8: fill the table, then stall
        while (m_cnt < N) begin
            flush("R8");
            plain("R8");
        end
        plain("R8");                                 // needs nothing, accepted
        flush("R8");
        plain("R8");                                 // stalled
        plain("R8");                                 // still stalled, flush kept (R5)

        // R10: restore to a live slot two past the oldest
        step(1,0,0,0,0,0,1,(m_head + 2) % N,"R10");
        plain("R10");                                // opens slot k+1
        step(0,0,0,0,0,0,1,(m_tail + 2) % N,"R10"); // not live, no effect
        flush("R10");
        plain("R10");

        // R9: drain everything in order
        while (m_cnt > 1) begin
            drain_head("R9");
            idle("R9");
        end
        repeat (3) idle("R9");
        chk(q_snap.size() == 0, "R6", "captures outstanding", q_snap.size(), 0);
        chk(q_rel.size() == 0, "R9", "releases outstanding", q_rel.size(), 0);
        chk(q_rst.size() == 0, "R10", "restores outstanding", q_rst.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule